// File: doc/BRIEF.md
# Halfword Instruction Prefetch Unit

This block is the fetch front end of a short two-stage pipeline whose instructions are mostly 16 bits wide. Each flash access returns one 32-bit word, which carries two halfword instructions. The unit hands decode one halfword per cycle, taking the first from the word as it arrives and the second from a small holding buffer. Because of this, flash needs a read strobe only on every second cycle while code runs straight through.

A redirect input carries a new halfword address. In the cycle it is raised, the unit drops whatever it had buffered and the data returning from flash. It then issues a read for the target word at once, so decode gets the target instruction on the very next cycle. When the target is the upper halfword of its word, only the upper lane enable of the flash bus is driven. When decode is not ready, the unit holds its output steady, raises a stall flag and issues no flash reads.

Halfword addresses are used throughout. Bit 0 of a halfword address picks the lane (0 = low bits 15:0, 1 = high bits 31:16 of the flash word), and the remaining bits form the word address.

Top module: `hpf_prefetch`

## Requirements
- R1: While reset is held, no flash read and no valid output occur. In the first cycle after release, a read is issued for the word of the reset address with both lane enables set.
- R2: Each valid output carries the halfword at the expected address, with `dec_pc` equal to that address. Addresses run in strict sequence from the last redirect target, advancing only when decode accepts. With `dec_ready` held high and no redirect, a valid output appears on every cycle.
- R3: Without a redirect, a flash read that enabled both lanes is never followed by a read in the next cycle. A run of straight aligned code therefore issues one read per two instructions.
- R4: A redirect issues a flash read in its own cycle for word `redir_addr[15:1]`. The lane enables are `2'b11` for an even target and `2'b10` for an odd target, so the low lane stays off.
- R5: In a redirect cycle `dec_valid` is low, and buffered or returning halfwords are discarded. In the next cycle `dec_valid` is high with `dec_pc` equal to the target.
- R6: `stall` equals `dec_valid & ~dec_ready`. No flash read occurs while it is high. Unless a redirect intervenes, the following cycle presents the same valid instruction and address again, and this holds even if the stall began in the cycle the flash data returned.
- R7: Whenever no flash read is issued, both lane enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Redirect request |
| redir_addr | input | 16 | Redirect target, halfword address |
| fl_rd_en | output | 1 | Flash read strobe |
| fl_rd_addr | output | 15 | Flash word address |
| fl_lane_en | output | 2 | Per-halfword lane enables of the flash bus |
| fl_rdata | input | 32 | Flash read data, valid the cycle after the strobe |
| dec_ready | input | 1 | Decode accepts the presented instruction |
| dec_valid | output | 1 | Instruction presented to decode |
| dec_instr | output | 16 | Halfword instruction |
| dec_pc | output | 16 | Halfword address of the instruction |
| stall | output | 1 | Valid instruction held because decode is not ready |

## Verification
Long runs of straight code with decode always ready show the one-read-per-two-instructions rhythm and continuous issue. These runs separate a correct holding buffer from one that refetches or leaves bubbles. Redirects to even and odd targets, including back-to-back redirects and redirects during a stall, show whether returning shadow data is really discarded and whether the low lane stays off. Random ready patterns, including a stall in the exact cycle flash data returns, show whether both halves of a word survive a held output. Randomly timed redirects to random targets cover interleavings that the directed cases miss.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    // Where the halfword presented to decode comes from in a given cycle
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_FLASH = 2'd1,
        SRC_HOLD  = 2'd2
    } hpf_src_e;

endpackage

// File: rtl/hpf_fetch_ctl.sv
module hpf_fetch_ctl #(
    parameter int LANES      = 2,
    parameter int WAW        = 15,
    parameter int RESET_WORD = 0,
    localparam int OFS_W     = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redir_valid,
    input  logic [WAW-1:0]     redir_word,
    input  logic [OFS_W-1:0]   redir_ofs,
    input  logic               buf_drained,
    output logic               rd_en,
    output logic [WAW-1:0]     rd_word,
    output logic [LANES-1:0]   lane_en,
    output logic               arr_valid,
    output logic [LANES-1:0]   arr_lanes,
    output logic [WAW-1:0]     arr_word
);

    typedef struct packed {
        logic [WAW-1:0]   fetch_word;
        logic             pend;
        logic [LANES-1:0] pend_lanes;
        logic [WAW-1:0]   pend_word;
    } fctl_t;

    fctl_t st_q, st_d;
    logic [LANES-1:0] mask;

    always_comb begin
        st_d = st_q;
        mask = '1;
        if (redir_valid) begin
            for (int i = 0; i < LANES; i++) begin
                mask[i] = (i >= int'(redir_ofs));
            end
        end
        rd_en   = rst_n && (redir_valid || buf_drained);
        rd_word = redir_valid ? redir_word : st_q.fetch_word;
        lane_en = rd_en ? mask : '0;

        st_d.pend       = rd_en;
        st_d.pend_lanes = lane_en;
        st_d.pend_word  = rd_word;
        if (rd_en) begin
            st_d.fetch_word = rd_word + WAW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fetch_word <= WAW'(RESET_WORD);
            st_q.pend       <= 1'b0;
            st_q.pend_lanes <= '0;
            st_q.pend_word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_valid = st_q.pend;
    assign arr_lanes = st_q.pend_lanes;
    assign arr_word  = st_q.pend_word;

    // A full-word read leaves a halfword behind, so no read follows it
    assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en && (lane_en == {LANES{1'b1}})) && !redir_valid) |-> !rd_en);

    // Data returning from flash always has at least one enabled lane
    assert_arrival_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en) |-> (arr_valid && (arr_lanes != '0)));

endmodule

// File: rtl/hpf_hold_buf.sv
module hpf_hold_buf
    import hpf_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int IW     = 16,
    parameter int WAW    = 15,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                arr_valid,
    input  logic [LANES-1:0]    arr_lanes,
    input  logic [LANES*IW-1:0] arr_data,
    input  logic [WAW-1:0]      arr_word,
    input  logic                dec_ready,
    output logic                out_valid,
    output logic [IW-1:0]       out_instr,
    output logic [OFS_W-1:0]    out_ofs,
    output logic [WAW-1:0]      out_word,
    output logic                drained
);

    typedef struct packed {
        logic [LANES-1:0]    valid;
        logic [LANES*IW-1:0] data;
        logic [WAW-1:0]      word;
    } hbuf_t;

    hbuf_t st_q, st_d;
    hpf_src_e src;
    logic [LANES-1:0]    eff_valid;
    logic [LANES*IW-1:0] eff_data;
    logic [WAW-1:0]      eff_word;
    logic [OFS_W-1:0]    sel;
    logic [LANES-1:0]    rem;

    always_comb begin
        st_d = st_q;
        if (arr_valid) begin
            src       = SRC_FLASH;
            eff_valid = arr_lanes;
            eff_data  = arr_data;
            eff_word  = arr_word;
        end else begin
            src       = (st_q.valid != '0) ? SRC_HOLD : SRC_IDLE;
            eff_valid = st_q.valid;
            eff_data  = st_q.data;
            eff_word  = st_q.word;
        end

        sel = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (eff_valid[i]) sel = OFS_W'(i);
        end

        out_valid = (src != SRC_IDLE) && !flush;
        out_instr = eff_data[sel*IW +: IW];
        out_ofs   = sel;
        out_word  = eff_word;

        rem = eff_valid;
        if (out_valid && dec_ready) rem[sel] = 1'b0;
        if (flush) rem = '0;
        drained = (rem == '0);

        st_d.valid = rem;
        st_d.data  = eff_data;
        st_d.word  = eff_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.data  <= '0;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A refused instruction is presented again unchanged
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid && !dec_ready) && !flush) |->
        (out_valid && $stable(out_instr) && $stable(out_ofs) && $stable(out_word)));

    // Returning flash data never coexists with held leftovers
    assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |-> ($past(drained) || $past(flush)));

endmodule

// File: rtl/hpf_prefetch.sv
module hpf_prefetch #(
    parameter int IW         = 16,
    parameter int LANES      = 2,
    parameter int AW         = 16,
    parameter int RESET_ADDR = 0,
    localparam int OFS_W     = $clog2(LANES),
    localparam int WAW       = AW - OFS_W,
    localparam int FLASH_W   = IW * LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redir_valid,
    input  logic [AW-1:0]      redir_addr,
    output logic               fl_rd_en,
    output logic [WAW-1:0]     fl_rd_addr,
    output logic [LANES-1:0]   fl_lane_en,
    input  logic [FLASH_W-1:0] fl_rdata,
    input  logic               dec_ready,
    output logic               dec_valid,
    output logic [IW-1:0]      dec_instr,
    output logic [AW-1:0]      dec_pc,
    output logic               stall
);

    logic               drained;
    logic               arr_valid;
    logic [LANES-1:0]   arr_lanes;
    logic [WAW-1:0]     arr_word;
    logic [OFS_W-1:0]   out_ofs;
    logic [WAW-1:0]     out_word;

    hpf_fetch_ctl #(
        .LANES     (LANES),
        .WAW       (WAW),
        .RESET_WORD(RESET_ADDR >> OFS_W)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .redir_valid(redir_valid),
        .redir_word (redir_addr[AW-1:OFS_W]),
        .redir_ofs  (redir_addr[OFS_W-1:0]),
        .buf_drained(drained),
        .rd_en      (fl_rd_en),
        .rd_word    (fl_rd_addr),
        .lane_en    (fl_lane_en),
        .arr_valid  (arr_valid),
        .arr_lanes  (arr_lanes),
        .arr_word   (arr_word)
    );

    hpf_hold_buf #(
        .LANES(LANES),
        .IW   (IW),
        .WAW  (WAW)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (redir_valid),
        .arr_valid(arr_valid),
        .arr_lanes(arr_lanes),
        .arr_data (fl_rdata),
        .arr_word (arr_word),
        .dec_ready(dec_ready),
        .out_valid(dec_valid),
        .out_instr(dec_instr),
        .out_ofs  (out_ofs),
        .out_word (out_word),
        .drained  (drained)
    );

    assign dec_pc = {out_word, out_ofs};
    assign stall  = dec_valid && !dec_ready;

    // Refill completes one cycle after a redirect, at the target address
    assert_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(redir_valid) && !redir_valid) |-> (dec_valid && (dec_pc == $past(redir_addr))));

    // Shadow instruction is never handed to decode on a redirect
    assert_shadow_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !dec_valid);

    // Flash stays quiet while decode holds back an instruction
    assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redir_valid) |-> !fl_rd_en);

    // Unaligned target leaves the low lane disabled
    assert_low_lane_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && (redir_addr[OFS_W-1:0] != '0)) |-> (fl_rd_en && !fl_lane_en[0]));

    // No lane toggles without a read strobe
    assert_lanes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rd_en |-> (fl_lane_en == '0));

endmodule

// File: tb/hpf_prefetch_bench.sv
module hpf_prefetch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic [15:0] redir_addr = '0;
    logic        fl_rd_en;
    logic [14:0] fl_rd_addr;
    logic [1:0]  fl_lane_en;
    logic [31:0] fl_rdata = '0;
    logic        dec_ready = 1'b0;
    logic        dec_valid;
    logic [15:0] dec_instr;
    logic [15:0] dec_pc;
    logic        stall;

    int vectors = 0;
    int fails = 0;
    int lane_hits = 0;
    int reads = 0;
    logic [15:0] exp_pc = '0;
    bit prev_full = 0, prev_redir = 0, prev_stall = 0;
    logic [15:0] prev_pc = '0, prev_instr = '0;

    always #5 clk = ~clk;

    hpf_prefetch u_hpf_prefetch (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_lane_en(fl_lane_en),
        .fl_rdata(fl_rdata), .dec_ready(dec_ready), .dec_valid(dec_valid),
        .dec_instr(dec_instr), .dec_pc(dec_pc), .stall(stall)
    );

    function automatic logic [15:0] hw_of(input logic [15:0] a);
        return 16'(a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    // Flash model: one-cycle latency, disabled lanes read as zero
    always_ff @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            fl_rdata[i*16 +: 16] <= (fl_rd_en && fl_lane_en[i]) ? hw_of({fl_rd_addr, i[0]}) : 16'h0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit rdy, input bit rv, input logic [15:0] tgt);
        @(negedge clk);
        dec_ready = rdy;
        redir_valid = rv;
        redir_addr = tgt;
        #1;
        if (rv) begin
            chk(!dec_valid, "R5 shadow dropped", 32'(dec_valid), 0);
            chk(fl_rd_en && fl_rd_addr == tgt[15:1], "R4 redirect read addr",
                {16'(fl_rd_en), 1'b0, fl_rd_addr}, {16'd1, 1'b0, tgt[15:1]});
            chk(fl_lane_en == (tgt[0] ? 2'b10 : 2'b11), "R4 lane enables",
                32'(fl_lane_en), tgt[0] ? 32'd2 : 32'd3);
            exp_pc = tgt;
        end else begin
            if (prev_redir)
                chk(dec_valid, "R5 refill next cycle", 32'(dec_valid), 1);
            if (prev_full)
                chk(!fl_rd_en, "R3 no read after full word", 32'(fl_rd_en), 0);
            if (prev_stall)
                chk(dec_valid && dec_pc == prev_pc && dec_instr == prev_instr, "R6 held output",
                    {dec_pc, dec_instr}, {prev_pc, prev_instr});
            if (dec_valid) begin
                chk(dec_pc == exp_pc, "R2 pc", 32'(dec_pc), 32'(exp_pc));
                chk(dec_instr == hw_of(exp_pc), "R2 instr", 32'(dec_instr), 32'(hw_of(exp_pc)));
                if (rdy) exp_pc++;
            end
        end
        chk(stall == (dec_valid && !rdy), "R6 stall flag", 32'(stall), 32'(dec_valid && !rdy));
        if (stall && !rv)
            chk(!fl_rd_en, "R6 no read in stall", 32'(fl_rd_en), 0);
        if (!fl_rd_en)
            chk(fl_lane_en == 2'b00, "R7 lanes idle", 32'(fl_lane_en), 0);
        if (fl_rd_en) reads++;
        lane_hits += int'(fl_lane_en[0]) + int'(fl_lane_en[1]);
        prev_full  = fl_rd_en && fl_lane_en == 2'b11;
        prev_redir = rv;
        prev_stall = stall && !rv;
        prev_pc    = dec_pc;
        prev_instr = dec_instr;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        int r0;
        void'($urandom(32'd1789));
        repeat (3) @(negedge clk);
        #1;
        chk(!fl_rd_en && !dec_valid, "R1 quiet in reset", {fl_rd_en, dec_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        dec_ready = 1'b1;
        #1;
        chk(fl_rd_en && fl_rd_addr == 15'd0 && fl_lane_en == 2'b11, "R1 first read",
            {fl_rd_en, fl_rd_addr, fl_lane_en}, {1'b1, 15'd0, 2'b11});
        chk(!dec_valid, "R1 no output yet", 32'(dec_valid), 0);
        prev_full = 1;
        exp_pc = 16'h0000;
        repeat (6) step(1, 0, 0);

        // R2/R3: straight aligned code, continuous issue, half-rate reads
        step(1, 1, 16'h0040);
        r0 = reads;
        for (int k = 0; k < 20; k++) begin
            step(1, 0, 0);
            chk(dec_valid, "R2 continuous issue", 32'(dec_valid), 1);
        end
        chk((reads - r0) == 10, "R3 reads per 20 instr", 32'(reads - r0), 10);

        // R4: unaligned target
        step(1, 1, 16'h0083);
        repeat (5) step(1, 0, 0);

        // R6: stall in the cycle flash data returns
        step(1, 1, 16'h0100);
        repeat (3) step(0, 0, 0);
        repeat (6) step(1, 0, 0);

        // R5: redirect during a stall, then back-to-back redirects
        step(0, 0, 0);
        step(1, 1, 16'h0200);
        step(1, 1, 16'h0010);
        step(1, 1, 16'h0031);
        repeat (4) step(1, 0, 0);

        // Random mix of ready patterns and redirects
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 10) < 7, ($urandom % 20) == 0, 16'($urandom));
        end

        $display("lane activations: %0d", lane_hits);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule